// File: doc/BRIEF.md
# Interrupt Redirection Dispatch Unit

This unit sits between a set of interrupt input lines and the interrupt message fabric of a multi-processor system. Each line has a redirection entry, presented as a flat table input. When a line is pulsed, the unit marks it pending. It later serves the lowest pending line. It reads that line's entry and turns the request into zero, one or several interrupt messages. Each message leaves over a valid/ready handshake.

A masked entry swallows the request. An entry that uses one of the two reserved delivery encodings produces no message and raises an error pulse. An entry in external-interrupt delivery mode first fetches its vector from the legacy controller through a request/acknowledge pair. In physical destination mode a single message goes to the 8-bit destination field. In logical destination mode that field is a mask: one message is issued per set bit, lowest bit first, addressed to the bit's index. A request naming a line outside the table raises a separate error pulse.

Entry layout (packed, most significant first): dest[22:15], mask[14], trig[13], pol[12], dmode[11], dlv[10:8], vec[7:0].

Top module: `irdu_dispatch`

## Requirements
- R1: A request is recorded as pending. When idle, the unit serves the lowest-numbered pending line first, so requests that arrive while it is busy are neither lost nor served out of line order.
- R2: An entry whose mask bit (bit 14) is 1 is discarded: no message is sent and no error is raised.
- R3: With dmode = 0 (physical), exactly one message is sent, and msg_dest_o equals the entry's dest field.
- R4: With dmode = 1 (logical), one message is sent for each set bit of dest, with msg_dest_o equal to that bit's index, in strictly ascending index order.
- R5: A logical entry with dest = 0 is accepted, sends no message, and leaves the unit idle again.
- R6: Each message carries the entry's vector, its delivery mode (dlv), its dmode, msg_level_o equal to pol, and msg_trig_o equal to trig.
- R7: With dlv = 3'b111 (external), ext_vec_req_o is held high until ext_vec_ack_i. The message vector is the ext_vec_i value sampled with the acknowledge, not the entry's vec field.
- R8: With dlv = 3'b011 or 3'b110 (reserved), no message is sent and err_mode_o pulses high for one cycle.
- R9: A request with req_line_i >= NUM_LINES sends no message and pulses err_line_o for one cycle, in the cycle after the request.
- R10: While msg_valid_o is high and msg_ready_i is low, msg_valid_o stays high and every message field stays unchanged.
- R11: busy_o rises when a line is accepted for delivery and falls after the final message handshake. msg_valid_o and ext_vec_req_o are low whenever busy_o is low.
- R12: After reset, msg_valid_o, busy_o, ext_vec_req_o, err_line_o and err_mode_o are all low, and no line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | One-cycle interrupt request pulse |
| req_line_i | input | LINE_W | Line number of the request |
| tbl_i | input | NUM_LINES*23 | Redirection entries, line 0 in the lowest bits |
| ext_vec_req_o | output | 1 | Vector request to the legacy controller |
| ext_vec_ack_i | input | 1 | Legacy controller acknowledge |
| ext_vec_i | input | 8 | Vector supplied by the legacy controller |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by the fabric |
| msg_dest_o | output | 8 | Destination processor ID |
| msg_vec_o | output | 8 | Interrupt vector |
| msg_dlv_o | output | 3 | Delivery mode |
| msg_dmode_o | output | 1 | Destination mode (0 physical, 1 logical) |
| msg_level_o | output | 1 | Level, taken from polarity |
| msg_trig_o | output | 1 | Trigger mode |
| busy_o | output | 1 | Unit is delivering an accepted line |
| err_line_o | output | 1 | Out-of-range line error pulse |
| err_mode_o | output | 1 | Reserved delivery mode error pulse |

## Verification
The properties assume that the legacy controller raises ext_vec_ack_i only while ext_vec_req_o is high. They also assume that tbl_i does not change while a line is pending or being delivered. The bench answers the vector request with a one-cycle acknowledge only after it has seen the request. It rewrites table entries only after a fixed idle gap, once every earlier request has drained. Requests are single-cycle pulses driven on the falling edge.

// File: rtl/irdu_pkg.sv
package irdu_pkg;

    localparam int DEST_W = 8;
    localparam int VEC_W  = 8;

    typedef enum logic [2:0] {
        DLV_FIXED  = 3'b000,
        DLV_LOWPRI = 3'b001,
        DLV_SMI    = 3'b010,
        DLV_RSV_A  = 3'b011,
        DLV_NMI    = 3'b100,
        DLV_INIT   = 3'b101,
        DLV_RSV_B  = 3'b110,
        DLV_EXTINT = 3'b111
    } dlv_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              trig;
        logic              pol;
        logic              dmode;
        logic [2:0]        dlv;
        logic [VEC_W-1:0]  vec;
    } redir_ent_t;

    localparam int ENTRY_W = $bits(redir_ent_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_SEND = 2'd2
    } disp_st_e;

    function automatic logic dlv_reserved(input logic [2:0] m);
        return (m == DLV_RSV_A) || (m == DLV_RSV_B);
    endfunction

endpackage

// File: rtl/irdu_first_set.sv
module irdu_first_set #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irdu_entry_sel.sv
module irdu_entry_sel
    import irdu_pkg::*;
#(
    parameter int N  = 24,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*ENTRY_W-1:0] tbl_i,
    input  logic [IW-1:0]        idx_i,
    output redir_ent_t           ent_o
);
    redir_ent_t ent_arr [N];

    for (genvar g = 0; g < N; g++) begin : g_slice
        assign ent_arr[g] = redir_ent_t'(tbl_i[g*ENTRY_W +: ENTRY_W]);
    end

    assign ent_o = ent_arr[idx_i];
endmodule

// File: rtl/irdu_dispatch.sv
module irdu_dispatch
    import irdu_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int LINE_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  logic [LINE_W-1:0]             req_line_i,
    input  logic [NUM_LINES*ENTRY_W-1:0]  tbl_i,
    output logic                          ext_vec_req_o,
    input  logic                          ext_vec_ack_i,
    input  logic [VEC_W-1:0]              ext_vec_i,
    output logic                          msg_valid_o,
    input  logic                          msg_ready_i,
    output logic [DEST_W-1:0]             msg_dest_o,
    output logic [VEC_W-1:0]              msg_vec_o,
    output logic [2:0]                    msg_dlv_o,
    output logic                          msg_dmode_o,
    output logic                          msg_level_o,
    output logic                          msg_trig_o,
    output logic                          busy_o,
    output logic                          err_line_o,
    output logic                          err_mode_o
);
    localparam int PIW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int DIW = $clog2(DEST_W);
    localparam logic [LINE_W:0] LINE_LIMIT = (LINE_W+1)'(NUM_LINES);

    typedef struct packed {
        disp_st_e              st;
        logic [NUM_LINES-1:0]  pend;
        redir_ent_t            ent;
        logic [DEST_W-1:0]     rem;
        logic                  err_line;
        logic                  err_mode;
    } disp_state_t;

    disp_state_t state_d, state_q;

    logic             pend_found;
    logic [PIW-1:0]   pend_idx;
    redir_ent_t       sel_ent;
    logic             scan_found;
    logic [DIW-1:0]   scan_idx;

    irdu_first_set #(.W(NUM_LINES), .IW(PIW)) u_pend_pick (
        .vec_i   (state_q.pend),
        .found_o (pend_found),
        .idx_o   (pend_idx)
    );

    irdu_entry_sel #(.N(NUM_LINES), .IW(PIW)) u_ent_sel (
        .tbl_i (tbl_i),
        .idx_i (pend_idx),
        .ent_o (sel_ent)
    );

    irdu_first_set #(.W(DEST_W), .IW(DIW)) u_dest_scan (
        .vec_i   (state_q.rem),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    always_comb begin
        logic [NUM_LINES-1:0] set_v;
        logic [NUM_LINES-1:0] clr_v;
        logic [DEST_W-1:0]    rem_next;

        state_d          = state_q;
        state_d.err_mode = 1'b0;
        state_d.err_line = req_valid_i && ({1'b0, req_line_i} >= LINE_LIMIT);
        clr_v            = '0;
        rem_next         = state_q.rem;

        for (int i = 0; i < NUM_LINES; i++) begin
            set_v[i] = req_valid_i && ({1'b0, req_line_i} == (LINE_W+1)'(i));
        end

        case (state_q.st)
            ST_IDLE: begin
                if (pend_found) begin
                    clr_v[pend_idx] = 1'b1;
                    state_d.ent     = sel_ent;
                    state_d.rem     = sel_ent.dest;
                    if (sel_ent.mask) begin
                        state_d.st = ST_IDLE;
                    end else if (dlv_reserved(sel_ent.dlv)) begin
                        state_d.err_mode = 1'b1;
                    end else if (sel_ent.dmode && (sel_ent.dest == '0)) begin
                        state_d.st = ST_IDLE;
                    end else if (sel_ent.dlv == DLV_EXTINT) begin
                        state_d.st = ST_VEC;
                    end else begin
                        state_d.st = ST_SEND;
                    end
                end
            end
            ST_VEC: begin
                if (ext_vec_ack_i) begin
                    state_d.ent.vec = ext_vec_i;
                    state_d.st      = ST_SEND;
                end
            end
            ST_SEND: begin
                if (msg_ready_i) begin
                    if (!state_q.ent.dmode) begin
                        state_d.st = ST_IDLE;
                    end else begin
                        rem_next    = state_q.rem & ~(DEST_W'(1) << scan_idx);
                        state_d.rem = rem_next;
                        if (rem_next == '0) state_d.st = ST_IDLE;
                    end
                end
            end
            default: state_d.st = ST_IDLE;
        endcase

        state_d.pend = (state_q.pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= '0;
            state_q.st <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o        = (state_q.st != ST_IDLE);
    assign ext_vec_req_o = (state_q.st == ST_VEC);
    assign msg_valid_o   = (state_q.st == ST_SEND);
    assign msg_dest_o    = state_q.ent.dmode ? (scan_found ? DEST_W'(scan_idx) : '0)
                                             : state_q.ent.dest;
    assign msg_vec_o     = state_q.ent.vec;
    assign msg_dlv_o     = state_q.ent.dlv;
    assign msg_dmode_o   = state_q.ent.dmode;
    assign msg_level_o   = state_q.ent.pol;
    assign msg_trig_o    = state_q.ent.trig;
    assign err_line_o    = state_q.err_line;
    assign err_mode_o    = state_q.err_mode;

endmodule

// File: rtl/irdu_checker.sv
module irdu_checker #(
    parameter int NUM_LINES = 24,
    parameter int LINE_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic [LINE_W-1:0] req_line_i,
    input logic              ext_vec_req_o,
    input logic              ext_vec_ack_i,
    input logic [7:0]        ext_vec_i,
    input logic              msg_valid_o,
    input logic              msg_ready_i,
    input logic [7:0]        msg_dest_o,
    input logic [7:0]        msg_vec_o,
    input logic [2:0]        msg_dlv_o,
    input logic              msg_dmode_o,
    input logic              msg_level_o,
    input logic              msg_trig_o,
    input logic              busy_o,
    input logic              err_line_o
);
    localparam logic [LINE_W:0] LIM = (LINE_W+1)'(NUM_LINES);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_dest_o)
            && $stable(msg_vec_o) && $stable(msg_dlv_o) && $stable(msg_dmode_o)
            && $stable(msg_level_o) && $stable(msg_trig_o)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!msg_valid_o && !ext_vec_req_o));

    assert_single_phys_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && msg_ready_i && !msg_dmode_o) |=> !msg_valid_o);

    assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && msg_ready_i && msg_dmode_o) |=>
            (!msg_valid_o || (msg_dest_o > $past(msg_dest_o))));

    assert_no_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> ((msg_dlv_o != 3'b011) && (msg_dlv_o != 3'b110)));

    assert_ext_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_vec_req_o && ext_vec_ack_i) |=>
            (msg_valid_o && (msg_vec_o == $past(ext_vec_i))));

    assert_err_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_line_o |-> ($past(req_valid_i) && ({1'b0, $past(req_line_i)} >= LIM)));

endmodule

bind irdu_dispatch irdu_checker #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid_i),
    .req_line_i    (req_line_i),
    .ext_vec_req_o (ext_vec_req_o),
    .ext_vec_ack_i (ext_vec_ack_i),
    .ext_vec_i     (ext_vec_i),
    .msg_valid_o   (msg_valid_o),
    .msg_ready_i   (msg_ready_i),
    .msg_dest_o    (msg_dest_o),
    .msg_vec_o     (msg_vec_o),
    .msg_dlv_o     (msg_dlv_o),
    .msg_dmode_o   (msg_dmode_o),
    .msg_level_o   (msg_level_o),
    .msg_trig_o    (msg_trig_o),
    .busy_o        (busy_o),
    .err_line_o    (err_line_o)
);

// File: tb/irdu_dispatch_tb_top.sv
`timescale 1ns/1ps
module irdu_dispatch_tb_top;
    import irdu_pkg::*;

    localparam int NL = 24;
    localparam int LW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [LW-1:0] req_line = '0;
    logic [NL*ENTRY_W-1:0] tbl_flat;
    redir_ent_t tbl [NL];
    logic ext_req, ext_ack = 1'b0;
    logic [7:0] ext_vec = 8'h9C;
    logic msg_valid, msg_ready = 1'b1;
    logic [7:0] msg_dest, msg_vec;
    logic [2:0] msg_dlv;
    logic msg_dmode, msg_level, msg_trig, busy, err_line, err_mode;

    int n_tests = 0, n_fail = 0;
    int m_cnt = 0, el_cnt = 0, em_cnt = 0;
    logic [7:0] m_dest [64];
    logic [7:0] m_vec [64];
    logic [2:0] m_dlv [64];
    logic       m_dmode [64];
    logic       m_lvl [64];
    logic       m_trig [64];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) tbl_flat[i*ENTRY_W +: ENTRY_W] = tbl[i];
    end

    irdu_dispatch #(.NUM_LINES(NL), .LINE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_line_i(req_line),
        .tbl_i(tbl_flat), .ext_vec_req_o(ext_req), .ext_vec_ack_i(ext_ack),
        .ext_vec_i(ext_vec), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
        .msg_dest_o(msg_dest), .msg_vec_o(msg_vec), .msg_dlv_o(msg_dlv),
        .msg_dmode_o(msg_dmode), .msg_level_o(msg_level), .msg_trig_o(msg_trig),
        .busy_o(busy), .err_line_o(err_line), .err_mode_o(err_mode)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (msg_valid && msg_ready && m_cnt < 64) begin
                m_dest[m_cnt] = msg_dest; m_vec[m_cnt] = msg_vec;
                m_dlv[m_cnt] = msg_dlv; m_dmode[m_cnt] = msg_dmode;
                m_lvl[m_cnt] = msg_level; m_trig[m_cnt] = msg_trig;
                m_cnt = m_cnt + 1;
            end
            if (err_line) el_cnt = el_cnt + 1;
            if (err_mode) em_cnt = em_cnt + 1;
        end
    end

    always @(negedge clk) ext_ack = ext_req && !ext_ack;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic redir_ent_t mk(input logic [7:0] v, input logic [2:0] d, input logic dm,
                                      input logic p, input logic t, input logic m, input logic [7:0] ds);
        redir_ent_t e;
        e.vec = v; e.dlv = d; e.dmode = dm; e.pol = p; e.trig = t; e.mask = m; e.dest = ds;
        return e;
    endfunction

    task automatic clear_log();
        m_cnt = 0; el_cnt = 0; em_cnt = 0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        req_valid = 1'b1; req_line = LW'(line);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!msg_valid && !busy && !ext_req, "R12 outputs", {msg_valid, busy, ext_req}, 0);
        chk(!err_line && !err_mode, "R12 errors", {err_line, err_mode}, 0);
        repeat (5) @(negedge clk);
        chk(m_cnt == 0 && !busy, "R12 nothing pending", m_cnt, 0);
    endtask

    task automatic t_physical();
        clear_log();
        tbl[3] = mk(8'h41, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h25);
        pulse(3);
        repeat (10) @(negedge clk);
        chk(m_cnt == 1, "R3 count", m_cnt, 1);
        chk(m_dest[0] == 8'h25, "R3 dest", m_dest[0], 8'h25);
        chk(m_vec[0] == 8'h41 && m_dlv[0] == 3'b000 && m_dmode[0] == 1'b0,
            "R6 vec/dlv/dmode", {m_vec[0], m_dlv[0], m_dmode[0]}, {8'h41, 3'b000, 1'b0});
        chk(m_lvl[0] == 1'b1 && m_trig[0] == 1'b1, "R6 level/trig", {m_lvl[0], m_trig[0]}, 2'b11);
    endtask

    task automatic t_logical();
        clear_log();
        tbl[5] = mk(8'h52, 3'b001, 1'b1, 1'b0, 1'b1, 1'b0, 8'b1010_0101);
        pulse(5);
        repeat (15) @(negedge clk);
        chk(m_cnt == 4, "R4 count", m_cnt, 4);
        chk(m_dest[0] == 0 && m_dest[1] == 2 && m_dest[2] == 5 && m_dest[3] == 7, "R4 order",
            {m_dest[0], m_dest[1], m_dest[2], m_dest[3]}, 32'h00020507);
        chk(m_vec[3] == 8'h52 && m_dlv[3] == 3'b001 && m_lvl[3] == 1'b0 && m_trig[3] == 1'b1,
            "R6 logical fields", {m_vec[3], m_dlv[3], m_lvl[3], m_trig[3]}, {8'h52, 3'b001, 2'b01});
    endtask

    task automatic t_logzero();
        clear_log();
        tbl[6] = mk(8'h60, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        pulse(6);
        repeat (8) @(negedge clk);
        chk(m_cnt == 0 && !busy, "R5 empty mask", m_cnt, 0);
    endtask

    task automatic t_masked();
        clear_log();
        tbl[7] = mk(8'h70, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03);
        pulse(7);
        repeat (8) @(negedge clk);
        chk(m_cnt == 0 && em_cnt == 0 && !busy, "R2 masked", m_cnt, 0);
    endtask

    task automatic t_extint();
        clear_log();
        tbl[8] = mk(8'h11, 3'b111, 1'b0, 1'b1, 1'b0, 1'b0, 8'h04);
        pulse(8);
        repeat (10) @(negedge clk);
        chk(m_cnt == 1, "R7 count", m_cnt, 1);
        chk(m_vec[0] == 8'h9C, "R7 ext vector", m_vec[0], 8'h9C);
        chk(m_dest[0] == 8'h04 && m_dlv[0] == 3'b111, "R7 dest/dlv", {m_dest[0], m_dlv[0]}, {8'h04, 3'b111});
    endtask

    task automatic t_reserved();
        clear_log();
        tbl[9]  = mk(8'h90, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
        tbl[10] = mk(8'hA0, 3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
        pulse(9);
        pulse(10);
        repeat (8) @(negedge clk);
        chk(m_cnt == 0, "R8 no message", m_cnt, 0);
        chk(em_cnt == 2, "R8 error pulses", em_cnt, 2);
    endtask

    task automatic t_badline();
        clear_log();
        pulse(30);
        repeat (6) @(negedge clk);
        chk(el_cnt == 1 && m_cnt == 0, "R9 bad line", {el_cnt, m_cnt}, {32'd1, 32'd0});
    endtask

    task automatic t_order();
        clear_log();
        tbl[4]  = mk(8'h04, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4);
        tbl[12] = mk(8'h0C, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd12);
        tbl[15] = mk(8'h0F, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd15);
        msg_ready = 1'b0;
        pulse(15);
        pulse(12);
        pulse(4);
        repeat (4) @(negedge clk);
        msg_ready = 1'b1;
        repeat (15) @(negedge clk);
        chk(m_cnt == 3, "R1 count", m_cnt, 3);
        chk(m_dest[0] == 15 && m_dest[1] == 4 && m_dest[2] == 12, "R1 order",
            {m_dest[0], m_dest[1], m_dest[2]}, 24'h0F040C);
    endtask

    task automatic t_backpressure();
        logic [7:0] d0, v0;
        clear_log();
        tbl[3] = mk(8'h33, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
        msg_ready = 1'b0;
        pulse(3);
        repeat (3) @(negedge clk);
        chk(msg_valid && busy, "R11 busy while held", {msg_valid, busy}, 2'b11);
        d0 = msg_dest; v0 = msg_vec;
        repeat (4) @(negedge clk);
        chk(msg_valid && msg_dest == d0 && msg_vec == v0 && msg_dlv == 3'b100, "R10 stable",
            {msg_valid, msg_dest, msg_vec}, {1'b1, d0, v0});
        msg_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(m_cnt == 1 && m_dest[0] == 8'h5A, "R10 delivered once", m_cnt, 1);
        chk(!busy && !msg_valid, "R11 idle after handshake", {busy, msg_valid}, 0);
    endtask

    initial begin
        for (int i = 0; i < NL; i++) tbl[i] = mk(8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_physical();
        t_logical();
        t_logzero();
        t_masked();
        t_extint();
        t_reserved();
        t_badline();
        t_order();
        t_backpressure();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule